// File: doc/BRIEF.md
# Thermal Operating-Point Transition Sequencer

This block moves a processing element between a nominal operating point and a throttled one as a thermal trip input comes and goes. An operating point is a pair: a frequency-ratio select and a 6-bit voltage code. The block decides the order of the two changes. On the way down it lowers the frequency first and only then reduces the voltage. On the way up it raises the voltage first and only then raises the frequency. At every moment the supply therefore covers what the clock demands.

The clock-ratio change is modelled as a switch window of a fixed number of cycles. While the window is open, bus traffic is held off. Edge interrupt pulses that arrive during the window are stored and released once the new frequency runs. The voltage moves one code at a time. After each code it waits a settle interval before the next code, or before the frequency change that follows the last one.

The trip level is examined only while the sequencer is idle, so a trip change during a sequence is deferred. The two target pairs are captured when a sequence starts.

Top module: `thermal_opp_seq`

## Requirements
- R1: After reset, ratio_sel_o equals BOOT_RATIO and vid_o equals BOOT_VID. busy_o, bus_block_o and irq_pend_o are all zero.
- R2: When trip_i is high while idle at the nominal point, ratio_sel_o takes thr_ratio_i on the next clock edge. bus_block_o is then high for exactly SWITCH_CYCLES cycles, and vid_o does not change while it is high.
- R3: vid_o is an unsigned 6-bit code, one code per 12.5 mV, and a larger code means a higher voltage. It moves by exactly one code per step toward its target. In a downward sequence the first step takes effect one cycle after the switch window closes, and the following steps come every VID_SETTLE_CYCLES cycles.
- R4: When trip_i is low while idle at the throttled point, vid_o steps toward nom_vid_i, with the first step one cycle after the trigger edge and steps VID_SETTLE_CYCLES apart. ratio_sel_o keeps its value until VID_SETTLE_CYCLES cycles after the last step. It then becomes nom_ratio_i and opens a switch window of SWITCH_CYCLES cycles.
- R5: ratio_sel_o changes only on the edge that opens a switch window. bus_block_o is high only inside switch windows.
- R6: An irq_edge_i bit seen outside a switch window appears on irq_pend_o for one cycle, one cycle later. Bits seen while the next cycle is inside a window are accumulated. irq_pend_o is zero throughout the window, and the accumulated bits appear for one cycle in the first cycle after the window.
- R7: busy_o is high from the cycle after a sequence is triggered until its final step has completed. It is low when idle, and while it is low neither ratio_sel_o nor vid_o changes.
- R8: A change of trip_i during a sequence does not alter that sequence. On returning to idle the trip level is compared again. If it differs from the point just reached, a new sequence starts on the next edge. If it no longer differs, none starts.
- R9: The target ratio and voltage inputs are sampled when a sequence starts. Later changes to them do not affect that sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trip_i | input | 1 | Thermal trip level, high means throttle |
| nom_ratio_i | input | RATIO_W | Nominal frequency ratio |
| nom_vid_i | input | VID_W | Nominal voltage code |
| thr_ratio_i | input | RATIO_W | Throttled frequency ratio |
| thr_vid_i | input | VID_W | Throttled voltage code |
| irq_edge_i | input | IRQ_W | Edge interrupt pulses, one bit per source |
| ratio_sel_o | output | RATIO_W | Frequency ratio currently selected |
| vid_o | output | VID_W | Voltage code issued to the regulator |
| bus_block_o | output | 1 | High while the frequency switch window is open |
| irq_pend_o | output | IRQ_W | Interrupt pulses delivered to the core |
| busy_o | output | 1 | High while a transition sequence runs |

## Verification
The hardest situation to reach is a trip change that arrives while a sequence is running, together with interrupt pulses that land inside a switch window. The stimulus reaches the first by starting an upward sequence and raising trip_i again during its voltage ramp. The upward sequence must then finish, and a downward one must begin on the edge after idle. A trip blip that reverts before idle must start nothing. For the second, interrupt pulses are timed on the trigger edge and in the middle of the window. The bench expects them to come out merged in the single cycle after the window closes.

// File: rtl/thermal_opp_pkg.sv
package thermal_opp_pkg;
    typedef enum logic [2:0] {
        SEQ_IDLE   = 3'd0,
        SEQ_SW_DN  = 3'd1,
        SEQ_VID_DN = 3'd2,
        SEQ_VID_UP = 3'd3,
        SEQ_SW_UP  = 3'd4
    } seq_state_e;
endpackage

// File: rtl/opp_dwell_timer.sv
// Shared countdown: loaded with an interval minus one, counts to zero and holds.
module opp_dwell_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         done_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done_o = (cnt_q == '0);
endmodule

// File: rtl/opp_vid_stepper.sv
// Holds the issued voltage code and moves it one code toward a target on request.
module opp_vid_stepper #(
    parameter int VID_W    = 6,
    parameter int BOOT_VID = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    input  logic [VID_W-1:0] target_i,
    output logic [VID_W-1:0] vid_o,
    output logic             at_target_o
);
    logic [VID_W-1:0] vid_d, vid_q;

    always_comb begin
        vid_d = vid_q;
        if (step_i && (vid_q != target_i)) begin
            if (target_i > vid_q) vid_d = vid_q + VID_W'(1);
            else                  vid_d = vid_q - VID_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vid_q <= VID_W'(BOOT_VID);
        else        vid_q <= vid_d;
    end

    assign vid_o       = vid_q;
    assign at_target_o = (vid_q == target_i);
endmodule

// File: rtl/opp_irq_gate.sv
// Passes interrupt pulses one cycle late, or stores them while a switch window is open.
module opp_irq_gate #(
    parameter int IRQ_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold_i,
    input  logic [IRQ_W-1:0] irq_i,
    output logic [IRQ_W-1:0] pend_o
);
    typedef struct packed {
        logic [IRQ_W-1:0] held;
        logic [IRQ_W-1:0] pend;
    } gate_t;

    gate_t gate_d, gate_q;

    always_comb begin
        gate_d = gate_q;
        if (hold_i) begin
            gate_d.held = gate_q.held | irq_i;
            gate_d.pend = '0;
        end else begin
            gate_d.pend = gate_q.held | irq_i;
            gate_d.held = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gate_q <= '0;
        else        gate_q <= gate_d;
    end

    assign pend_o = gate_q.pend;
endmodule

// File: rtl/thermal_opp_seq.sv
module thermal_opp_seq
    import thermal_opp_pkg::*;
#(
    parameter int RATIO_W           = 5,
    parameter int VID_W             = 6,
    parameter int IRQ_W             = 4,
    parameter int SWITCH_CYCLES     = 1250,
    parameter int VID_SETTLE_CYCLES = 500,
    parameter int BOOT_RATIO        = 12,
    parameter int BOOT_VID          = 40
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               trip_i,
    input  logic [RATIO_W-1:0] nom_ratio_i,
    input  logic [VID_W-1:0]   nom_vid_i,
    input  logic [RATIO_W-1:0] thr_ratio_i,
    input  logic [VID_W-1:0]   thr_vid_i,
    input  logic [IRQ_W-1:0]   irq_edge_i,
    output logic [RATIO_W-1:0] ratio_sel_o,
    output logic [VID_W-1:0]   vid_o,
    output logic               bus_block_o,
    output logic [IRQ_W-1:0]   irq_pend_o,
    output logic               busy_o
);
    localparam int TMR_MAX = (SWITCH_CYCLES > VID_SETTLE_CYCLES) ? SWITCH_CYCLES
                                                                 : VID_SETTLE_CYCLES;
    localparam int TMR_W   = (TMR_MAX > 1) ? $clog2(TMR_MAX) : 1;
    localparam logic [TMR_W-1:0] SW_LOAD  = TMR_W'(SWITCH_CYCLES - 1);
    localparam logic [TMR_W-1:0] VID_LOAD = TMR_W'(VID_SETTLE_CYCLES - 1);

    typedef struct packed {
        seq_state_e         state;
        logic               throttled;
        logic [RATIO_W-1:0] ratio;
        logic [RATIO_W-1:0] tgt_ratio;
        logic [VID_W-1:0]   tgt_vid;
    } ctl_t;

    ctl_t             ctl_d, ctl_q;
    logic             tmr_load;
    logic [TMR_W-1:0] tmr_val;
    logic             tmr_done;
    logic             vid_step;
    logic             vid_at_tgt;
    logic             window_next;
    logic [VID_W-1:0] vid_cur;

    always_comb begin
        ctl_d    = ctl_q;
        tmr_load = 1'b0;
        tmr_val  = SW_LOAD;
        vid_step = 1'b0;
        unique case (ctl_q.state)
            SEQ_IDLE: begin
                if (trip_i && !ctl_q.throttled) begin
                    ctl_d.state     = SEQ_SW_DN;
                    ctl_d.throttled = 1'b1;
                    ctl_d.ratio     = thr_ratio_i;
                    ctl_d.tgt_vid   = thr_vid_i;
                    tmr_load        = 1'b1;
                    tmr_val         = SW_LOAD;
                end else if (!trip_i && ctl_q.throttled) begin
                    ctl_d.state     = SEQ_VID_UP;
                    ctl_d.throttled = 1'b0;
                    ctl_d.tgt_ratio = nom_ratio_i;
                    ctl_d.tgt_vid   = nom_vid_i;
                end
            end
            SEQ_SW_DN: begin
                if (tmr_done) ctl_d.state = SEQ_VID_DN;
            end
            SEQ_VID_DN: begin
                if (tmr_done) begin
                    if (vid_at_tgt) begin
                        ctl_d.state = SEQ_IDLE;
                    end else begin
                        vid_step = 1'b1;
                        tmr_load = 1'b1;
                        tmr_val  = VID_LOAD;
                    end
                end
            end
            SEQ_VID_UP: begin
                if (tmr_done) begin
                    if (vid_at_tgt) begin
                        ctl_d.state = SEQ_SW_UP;
                        ctl_d.ratio = ctl_q.tgt_ratio;
                        tmr_load    = 1'b1;
                        tmr_val     = SW_LOAD;
                    end else begin
                        vid_step = 1'b1;
                        tmr_load = 1'b1;
                        tmr_val  = VID_LOAD;
                    end
                end
            end
            SEQ_SW_UP: begin
                if (tmr_done) ctl_d.state = SEQ_IDLE;
            end
            default: ctl_d.state = SEQ_IDLE;
        endcase
        window_next = (ctl_d.state == SEQ_SW_DN) || (ctl_d.state == SEQ_SW_UP);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.state     <= SEQ_IDLE;
            ctl_q.throttled <= 1'b0;
            ctl_q.ratio     <= RATIO_W'(BOOT_RATIO);
            ctl_q.tgt_ratio <= RATIO_W'(BOOT_RATIO);
            ctl_q.tgt_vid   <= VID_W'(BOOT_VID);
        end else begin
            ctl_q <= ctl_d;
        end
    end

    opp_dwell_timer #(.W(TMR_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .done_o     (tmr_done)
    );

    opp_vid_stepper #(.VID_W(VID_W), .BOOT_VID(BOOT_VID)) u_vid (
        .clk         (clk),
        .rst_n       (rst_n),
        .step_i      (vid_step),
        .target_i    (ctl_q.tgt_vid),
        .vid_o       (vid_cur),
        .at_target_o (vid_at_tgt)
    );

    opp_irq_gate #(.IRQ_W(IRQ_W)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .hold_i (window_next),
        .irq_i  (irq_edge_i),
        .pend_o (irq_pend_o)
    );

    assign ratio_sel_o = ctl_q.ratio;
    assign vid_o       = vid_cur;
    assign bus_block_o = (ctl_q.state == SEQ_SW_DN) || (ctl_q.state == SEQ_SW_UP);
    assign busy_o      = (ctl_q.state != SEQ_IDLE);
endmodule

// File: rtl/thermal_opp_seq_chk.sv
module thermal_opp_seq_chk #(
    parameter int RATIO_W = 5,
    parameter int VID_W   = 6,
    parameter int IRQ_W   = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [RATIO_W-1:0] ratio_sel_o,
    input logic [VID_W-1:0]   vid_o,
    input logic               bus_block_o,
    input logic [IRQ_W-1:0]   irq_pend_o,
    input logic               busy_o
);
    // R5
    ratio_only_at_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ratio_sel_o) |-> bus_block_o);

    // R2
    vid_frozen_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_block_o |-> $stable(vid_o));

    // R3
    vid_one_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(vid_o) |-> ((vid_o == $past(vid_o) + VID_W'(1)) ||
                             ($past(vid_o) == vid_o + VID_W'(1))));

    // R7
    block_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_block_o |-> busy_o);

    // R7
    idle_is_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> ($stable(vid_o) && $stable(ratio_sel_o)));

    // R6
    no_irq_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_block_o |-> (irq_pend_o == '0));
endmodule

bind thermal_opp_seq thermal_opp_seq_chk #(
    .RATIO_W (RATIO_W),
    .VID_W   (VID_W),
    .IRQ_W   (IRQ_W)
) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ratio_sel_o (ratio_sel_o),
    .vid_o       (vid_o),
    .bus_block_o (bus_block_o),
    .irq_pend_o  (irq_pend_o),
    .busy_o      (busy_o)
);

// File: tb/test_thermal_opp_seq.sv
module test_thermal_opp_seq;
    localparam int RW   = 5;
    localparam int VW   = 6;
    localparam int IW   = 4;
    localparam int SW   = 5;
    localparam int SET  = 3;
    localparam int NOMR = 12;
    localparam int NOMV = 40;
    localparam int THRR = 7;
    localparam int THRV = 36;
    localparam int NSTEP = NOMV - THRV;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          trip_i = 1'b0;
    logic [RW-1:0] nom_ratio_i = RW'(NOMR);
    logic [VW-1:0] nom_vid_i = VW'(NOMV);
    logic [RW-1:0] thr_ratio_i = RW'(THRR);
    logic [VW-1:0] thr_vid_i = VW'(THRV);
    logic [IW-1:0] irq_edge_i = '0;
    logic [RW-1:0] ratio_sel_o;
    logic [VW-1:0] vid_o;
    logic          bus_block_o;
    logic [IW-1:0] irq_pend_o;
    logic          busy_o;

    int n_run = 0;
    int n_fail = 0;
    bit ended = 1'b0;

    always #2 clk = ~clk;

    thermal_opp_seq #(
        .RATIO_W(RW), .VID_W(VW), .IRQ_W(IW),
        .SWITCH_CYCLES(SW), .VID_SETTLE_CYCLES(SET),
        .BOOT_RATIO(NOMR), .BOOT_VID(NOMV)
    ) i_thermal_opp_seq (
        .clk(clk), .rst_n(rst_n), .trip_i(trip_i),
        .nom_ratio_i(nom_ratio_i), .nom_vid_i(nom_vid_i),
        .thr_ratio_i(thr_ratio_i), .thr_vid_i(thr_vid_i),
        .irq_edge_i(irq_edge_i), .ratio_sel_o(ratio_sel_o), .vid_o(vid_o),
        .bus_block_o(bus_block_o), .irq_pend_o(irq_pend_o), .busy_o(busy_o)
    );

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    task automatic chk(string req, string what, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // advance to the next sampling point, half a period after a rising edge
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wait_idle(string req);
        for (int i = 0; i < 300; i++) begin
            if (!busy_o) return;
            tick();
        end
        chk(req, "idle timeout", 1, 0);
    endtask

    function automatic int imin(int a, int b);
        return (a < b) ? a : b;
    endfunction

    task automatic t_reset();
        chk("R1", "ratio", int'(ratio_sel_o), NOMR);
        chk("R1", "vid", int'(vid_o), NOMV);
        chk("R1", "busy", int'(busy_o), 0);
        chk("R1", "block", int'(bus_block_o), 0);
        chk("R1", "pend", int'(irq_pend_o), 0);
    endtask

    // nominal -> throttled, sampled after every edge E0..
    task automatic t_down();
        int last;
        last = SW + 1 + NSTEP * SET;
        trip_i = 1'b1;
        for (int c = 0; c <= last + 2; c++) begin
            int steps;
            tick();
            steps = (c < SW + 1) ? 0 : imin(NSTEP, (c - SW - 1) / SET + 1);
            chk("R2", "ratio", int'(ratio_sel_o), THRR);
            chk("R2", "block", int'(bus_block_o), (c < SW) ? 1 : 0);
            chk("R3", "vid", int'(vid_o), NOMV - steps);
            chk("R7", "busy", int'(busy_o), (c < last) ? 1 : 0);
        end
    endtask

    // throttled -> nominal; targets disturbed after start (R9)
    task automatic t_up();
        int u;
        u = 1 + NSTEP * SET;
        trip_i = 1'b0;
        for (int c = 0; c <= u + SW + 2; c++) begin
            int steps;
            tick();
            if (c == 0) begin
                nom_vid_i   = VW'(50);
                nom_ratio_i = RW'(3);
            end
            steps = (c < 1) ? 0 : imin(NSTEP, (c - 1) / SET + 1);
            chk("R4", "vid", int'(vid_o), THRV + steps);
            chk("R4", "ratio", int'(ratio_sel_o), (c >= u) ? NOMR : THRR);
            chk("R5", "block", int'(bus_block_o), (c >= u && c < u + SW) ? 1 : 0);
            chk("R7", "busy", int'(busy_o), (c < u + SW) ? 1 : 0);
        end
        chk("R9", "final vid", int'(vid_o), NOMV);
        nom_vid_i   = VW'(NOMV);
        nom_ratio_i = RW'(NOMR);
    endtask

    task automatic t_irq();
        // outside any window: one cycle late, one cycle wide
        irq_edge_i = 4'b1000;
        tick();
        irq_edge_i = '0;
        chk("R6", "idle pass", int'(irq_pend_o), 4'b1000);
        tick();
        chk("R6", "idle clear", int'(irq_pend_o), 0);
        // pulses on the trigger edge and mid-window
        trip_i = 1'b1;
        irq_edge_i = 4'b0001;
        for (int c = 0; c <= SW + 1; c++) begin
            tick();
            irq_edge_i = (c == 2) ? 4'b0100 : 4'b0000;
            if (c < SW)
                chk("R6", "held in window", int'(irq_pend_o), 0);
            else if (c == SW)
                chk("R6", "release", int'(irq_pend_o), 4'b0101);
            else
                chk("R6", "after release", int'(irq_pend_o), 0);
        end
        wait_idle("R6");
        chk("R6", "vid after", int'(vid_o), THRV);
    endtask

    task automatic t_defer();
        int u;
        u = 1 + NSTEP * SET;
        trip_i = 1'b0;
        for (int c = 0; c <= u + SW; c++) begin
            tick();
            if (c == 2) trip_i = 1'b1;
            if (c == u + SW - 1) begin
                chk("R8", "up finished block", int'(bus_block_o), 1);
                chk("R8", "up finished ratio", int'(ratio_sel_o), NOMR);
            end
            if (c == u + SW) begin
                chk("R8", "idle gap busy", int'(busy_o), 0);
                chk("R8", "idle gap vid", int'(vid_o), NOMV);
            end
        end
        tick();
        chk("R8", "new down ratio", int'(ratio_sel_o), THRR);
        chk("R8", "new down block", int'(bus_block_o), 1);
        wait_idle("R8");
        // blip that reverts before idle starts nothing
        trip_i = 1'b0;
        repeat (4) tick();
        trip_i = 1'b1;
        repeat (2) tick();
        trip_i = 1'b0;
        wait_idle("R8");
        for (int i = 0; i < 10; i++) begin
            tick();
            chk("R8", "blip busy", int'(busy_o), 0);
        end
        chk("R8", "blip ratio", int'(ratio_sel_o), NOMR);
        chk("R8", "blip vid", int'(vid_o), NOMV);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_down();
        t_up();
        t_irq();
        t_defer();
        finish_run();
    end
endmodule